// File: doc/BRIEF.md
# Storage Card Clock Generator with Phase Taps

This block produces the clock for a storage card interface. It takes a 24 MHz reference clock, a faster PLL clock and one 32-bit control word. A glitch-free multiplexer picks the source clock. A two-stage divider brings that clock down to the card rate: a power-of-two prescaler followed by an integer divider. Two tapped delay lines place a data-drive enable and a data-sample strobe a programmable number of source cycles after the card clock's falling and rising edges.

Software works out the divider and delay values for a given card speed and writes them into the control word. The block picks up a new word only when the current output period has completed, so reprogramming never cuts a pulse short. Typical delay settings by speed band are sample 7 with drive 0 for identification speed, sample 5 with drive 0 up to 25 MHz, sample 5 with drive 3 up to 50 MHz, and sample 4 with drive 2 above that.

Top module: `card_clk_gen`

## Requirements
- R1: While the active enable bit (control bit 31) is 0, card_clk, drv_en and smp_stb are all 0, whatever the other fields hold; this is also the state after reset.
- R2: With enable set, the card clock period is D = 2^N * (F+1) source cycles, where N is control bits 17:16 and F is control bits 3:0 (the divider value minus one).
- R3: For D of 2 or more, card_clk is high for floor(D/2) source cycles and low for the rest, so an odd D gives a high time one source cycle shorter than the low time.
- R4: When N = 0 and F = 0 (D = 1), card_clk follows the selected source clock itself, with period and high time equal to those of the source.
- R5: Control bit 24 selects the source: 0 for the reference clock, 1 for the PLL clock; the divided period and duty follow R2 and R3 in cycles of the selected clock.
- R6: smp_stb is high for one source cycle, S source cycles after the cycle in which card_clk goes high, where S is control bits 22:20 (0 to 7); it repeats every period.
- R7: drv_en is high for one source cycle, P source cycles after the cycle in which card_clk goes low, where P is control bits 10:8 (0 to 7); it repeats every period.
- R8: A new control word written while the output is running takes effect only at the start of the next period; the period in progress completes with its old high and low times.
- R9: Changing the source select produces no card_clk high or low pulse shorter than half a period of the faster source clock at the programmed division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 24 MHz reference clock |
| clk_pll | input | 1 | Faster PLL clock |
| rst | input | 1 | Synchronous active-high reset, held across several cycles of both clocks |
| ctrl_word | input | 32 | Control word: enable, source select, N, divider minus one, drive and sample delays |
| card_clk | output | 1 | Divided card clock |
| drv_en | output | 1 | One-source-cycle enable for launching output data |
| smp_stb | output | 1 | One-source-cycle strobe for sampling input data |

## Verification
The assertions assume that the control word is quasi-static. It is changed rarely and held long enough for the selected clock to capture it. They also assume that both input clocks run throughout reset, so that the multiplexer comes up on the reference clock and the divider's synchronous reset is clocked. The bench meets these assumptions. It changes the control word only on reference falling edges, holds reset for twenty reference cycles with both clocks running, and then waits hundreds of source cycles before it measures anything. The one exception is the directed reload test, which writes a new word in the middle of a period on purpose.

// File: rtl/cclk_pkg.sv
package cclk_pkg;

    localparam int N_W    = 2;
    localparam int M_W    = 4;
    localparam int DLY_W  = 3;
    localparam int PRE_CW = (1 << N_W) - 1;
    localparam int POS_W  = M_W + PRE_CW;

    localparam int BIT_EN  = 31;
    localparam int BIT_SRC = 24;
    localparam int SMP_LSB = 20;
    localparam int N_LSB   = 16;
    localparam int OUT_LSB = 8;
    localparam int M_LSB   = 0;

    typedef struct packed {
        logic             en;
        logic             src;
        logic [DLY_W-1:0] smp_dly;
        logic [N_W-1:0]   n;
        logic [DLY_W-1:0] out_dly;
        logic [M_W-1:0]   m_m1;
    } cclk_cfg_t;

    function automatic cclk_cfg_t cfg_decode(input logic [31:0] w);
        cclk_cfg_t c;
        c.en      = w[BIT_EN];
        c.src     = w[BIT_SRC];
        c.smp_dly = w[SMP_LSB +: DLY_W];
        c.n       = w[N_LSB +: N_W];
        c.out_dly = w[OUT_LSB +: DLY_W];
        c.m_m1    = w[M_LSB +: M_W];
        return c;
    endfunction

    // last prescaler count for a given exponent: 2^n - 1
    function automatic logic [PRE_CW-1:0] pre_top(input logic [N_W-1:0] n);
        logic [PRE_CW:0] sh;
        sh = (PRE_CW+1)'(1) << n;
        sh = sh - (PRE_CW+1)'(1);
        return sh[PRE_CW-1:0];
    endfunction

    function automatic logic is_bypass(input cclk_cfg_t c);
        return (c.n == '0) && (c.m_m1 == '0);
    endfunction

    // floor of the total division by two
    function automatic logic [POS_W-1:0] half_of(input cclk_cfg_t c);
        logic [POS_W:0] d;
        d = (POS_W+1)'(c.m_m1) + (POS_W+1)'(1);
        d = d << c.n;
        return d[POS_W:1];
    endfunction

    // position inside the output period in source cycles
    function automatic logic [POS_W-1:0] pos_of(input logic [M_W-1:0] m,
                                               input logic [PRE_CW-1:0] pre,
                                               input logic [N_W-1:0] n);
        logic [POS_W-1:0] p;
        p = POS_W'(m) << n;
        return p | POS_W'(pre);
    endfunction

endpackage

// File: rtl/cclk_src_mux.sv
module cclk_src_mux #(
    parameter int SYNC = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_b,
    output logic clk_out,
    output logic a_on,
    output logic b_on
);

    logic [SYNC-1:0] a_sync;
    logic [SYNC-1:0] b_sync;

    // each leg closes on its own falling edge, opens only after the other is shut
    always_ff @(negedge clk_a) begin
        if (rst) a_sync <= '1;
        else     a_sync <= {a_sync[SYNC-2:0], !sel_b && !b_on};
    end

    always_ff @(negedge clk_b) begin
        if (rst) b_sync <= '0;
        else     b_sync <= {b_sync[SYNC-2:0], sel_b && !a_on};
    end

    assign a_on    = a_sync[SYNC-1];
    assign b_on    = b_sync[SYNC-1];
    assign clk_out = (clk_a & a_on) | (clk_b & b_on);

endmodule

// File: rtl/cclk_divider.sv
module cclk_divider
    import cclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ctrl_word,
    output cclk_cfg_t   cfg_q,
    output logic        card_q,
    output logic        gate_q,
    output logic        nxt_en,
    output logic        evt_rise,
    output logic        evt_fall,
    output logic        per_end
);

    logic [PRE_CW-1:0] pre_q, nxt_pre;
    logic [M_W-1:0]    m_q, nxt_m;
    logic              pre_wrap, load, nxt_byp;
    cclk_cfg_t         nxt_cfg;
    logic [POS_W-1:0]  nxt_pos, nxt_half;

    assign pre_wrap = (pre_q == pre_top(cfg_q.n));
    assign per_end  = cfg_q.en && pre_wrap && (m_q == cfg_q.m_m1);
    assign load     = !cfg_q.en || per_end;

    always_comb begin
        nxt_cfg = load ? cfg_decode(ctrl_word) : cfg_q;
        if (load) begin
            nxt_pre = '0;
            nxt_m   = '0;
        end else begin
            nxt_pre = pre_wrap ? '0 : pre_q + 1'b1;
            nxt_m   = pre_wrap ? m_q + 1'b1 : m_q;
        end
        nxt_pos  = pos_of(nxt_m, nxt_pre, nxt_cfg.n);
        nxt_half = half_of(nxt_cfg);
        nxt_byp  = is_bypass(nxt_cfg);
        nxt_en   = nxt_cfg.en;
        evt_rise = nxt_en && (nxt_byp || (nxt_pos == '0));
        evt_fall = nxt_en && (nxt_byp || (nxt_pos == nxt_half));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            pre_q  <= '0;
            m_q    <= '0;
            card_q <= 1'b0;
        end else begin
            cfg_q  <= nxt_cfg;
            pre_q  <= nxt_pre;
            m_q    <= nxt_m;
            card_q <= nxt_en && !nxt_byp && (nxt_pos < nxt_half);
        end
    end

    // divide-by-one passes the source through a gate that moves only while it is low
    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= cfg_q.en && is_bypass(cfg_q);
    end

endmodule

// File: rtl/cclk_phase_tap.sv
module cclk_phase_tap
    import cclk_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt,
    input  logic [DLY_W-1:0] dly,
    output logic             stb
);

    logic [DEPTH-1:0] line;

    always_ff @(posedge clk) begin
        if (rst || clr) line <= '0;
        else            line <= {line[DEPTH-2:0], evt};
    end

    assign stb = line[dly];

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import cclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_ref,
    input  logic        clk_pll,
    input  logic        rst,
    input  logic [31:0] ctrl_word,
    output logic        card_clk,
    output logic        drv_en,
    output logic        smp_stb
);

    localparam int TAP_DEPTH = 1 << DLY_W;
    localparam int N_TAPS    = 2;

    logic       src_clk, a_on, b_on;
    cclk_cfg_t  cfg_q;
    logic       div_card, gate_q, nxt_en, evt_rise, evt_fall, per_end;

    logic [N_TAPS-1:0] tap_evt;
    logic [N_TAPS-1:0] tap_stb;
    logic [DLY_W-1:0]  tap_dly [N_TAPS];

    cclk_src_mux #(.SYNC(SYNC_STAGES)) u_mux (
        .clk_a   (clk_ref),
        .clk_b   (clk_pll),
        .rst     (rst),
        .sel_b   (cfg_q.src),
        .clk_out (src_clk),
        .a_on    (a_on),
        .b_on    (b_on)
    );

    cclk_divider u_div (
        .clk       (src_clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .cfg_q     (cfg_q),
        .card_q    (div_card),
        .gate_q    (gate_q),
        .nxt_en    (nxt_en),
        .evt_rise  (evt_rise),
        .evt_fall  (evt_fall),
        .per_end   (per_end)
    );

    // tap 0: sample side, timed from rising edges; tap 1: drive side, from falling edges
    assign tap_evt    = {evt_fall, evt_rise};
    assign tap_dly[0] = cfg_q.smp_dly;
    assign tap_dly[1] = cfg_q.out_dly;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        cclk_phase_tap #(.DEPTH(TAP_DEPTH)) u_tap (
            .clk (src_clk),
            .rst (rst),
            .clr (!nxt_en),
            .evt (tap_evt[g]),
            .dly (tap_dly[g]),
            .stb (tap_stb[g])
        );
    end

    assign smp_stb  = tap_stb[0];
    assign drv_en   = tap_stb[1];
    assign card_clk = gate_q ? src_clk : div_card;

endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk
    import cclk_pkg::*;
(
    input logic      src_clk,
    input logic      clk_ref,
    input logic      rst,
    input cclk_cfg_t act_cfg,
    input logic      per_end,
    input logic      div_card,
    input logic      smp_stb,
    input logic      drv_en,
    input logic      a_on,
    input logic      b_on
);

    // R1: a disabled configuration keeps every output quiet
    p_off_quiet_r1: assert property (@(posedge src_clk) disable iff (rst)
        !act_cfg.en |-> (!div_card && !smp_stb && !drv_en))
        else $error("p_off_quiet_r1");

    // R2: a divided rising edge opens a period, never lands inside one
    p_rise_at_start_r2: assert property (@(posedge src_clk) disable iff (rst)
        $rose(div_card) |-> $past(!act_cfg.en || per_end))
        else $error("p_rise_at_start_r2");

    // R8: the active configuration moves only at a period boundary or while idle
    p_cfg_hold_r8: assert property (@(posedge src_clk) disable iff (rst)
        (act_cfg != $past(act_cfg)) |-> $past(!act_cfg.en || per_end))
        else $error("p_cfg_hold_r8");

    // R9: the two source legs are never open together
    p_src_onehot_r9: assert property (@(posedge clk_ref) disable iff (rst)
        $onehot0({a_on, b_on}))
        else $error("p_src_onehot_r9");

endmodule

bind card_clk_gen card_clk_gen_chk u_chk (
    .src_clk  (src_clk),
    .clk_ref  (clk_ref),
    .rst      (rst),
    .act_cfg  (cfg_q),
    .per_end  (per_end),
    .div_card (div_card),
    .smp_stb  (smp_stb),
    .drv_en   (drv_en),
    .a_on     (a_on),
    .b_on     (b_on)
);

// File: tb/test_card_clk_gen.sv
`timescale 1ns/1ps
module test_card_clk_gen;

    localparam int  REF_PERIOD = 42;
    localparam int  PLL_PERIOD = 10;
    localparam int  WD_CYCLES  = 150000;
    localparam real TOL        = 0.01;

    logic        clk_ref = 1'b0;
    logic        clk_pll = 1'b0;
    logic        rst     = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic        card_clk, drv_en, smp_stb;

    int n_cmp = 0;
    int n_bad = 0;

    bit cs [0:299];
    bit ss [0:299];
    bit ds [0:299];

    real t_rise = 0.0, t_fall = 0.0;
    real hi_min = 1.0e9, lo_min = 1.0e9;
    bit  mon = 1'b0, have_rise = 1'b0, have_fall = 1'b0;

    always #(REF_PERIOD/2) clk_ref = ~clk_ref;
    always #(PLL_PERIOD/2) clk_pll = ~clk_pll;

    card_clk_gen i_card_clk_gen (
        .clk_ref   (clk_ref),
        .clk_pll   (clk_pll),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .card_clk  (card_clk),
        .drv_en    (drv_en),
        .smp_stb   (smp_stb)
    );

    // pulse-width monitor for the source switch test
    always @(posedge card_clk) begin
        if (mon && have_fall && ($realtime - t_fall) < lo_min) lo_min = $realtime - t_fall;
        t_rise    = $realtime;
        have_rise = mon;
    end
    always @(negedge card_clk) begin
        if (mon && have_rise && ($realtime - t_rise) < hi_min) hi_min = $realtime - t_rise;
        t_fall    = $realtime;
        have_fall = mon;
    end

    function automatic int pmod(int a, int b);
        return ((a % b) + b) % b;
    endfunction

    task automatic check(bit ok, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // layout: [31] enable, [24] source, [22:20] sample delay, [17:16] N, [10:8] drive delay, [3:0] F
    task automatic set_ctrl(bit en, bit src, int smp, int n, int od, int f);
        ctrl_word = '0;
        ctrl_word[31]    = en;
        ctrl_word[24]    = src;
        ctrl_word[22:20] = 3'(smp);
        ctrl_word[17:16] = 2'(n);
        ctrl_word[10:8]  = 3'(od);
        ctrl_word[3:0]   = 4'(f);
    endtask

    task automatic capture(int w);
        for (int c = 0; c < w; c++) begin
            @(negedge clk_ref);
            cs[c] = card_clk;
            ss[c] = smp_stb;
            ds[c] = drv_en;
        end
    endtask

    task automatic quiet_check(string what, int w);
        int busy = 0;
        capture(w);
        for (int c = 0; c < w; c++) if (cs[c] || ss[c] || ds[c]) busy++;
        check(busy == 0, what, busy, 0);
    endtask

    task automatic run_div(int n, int f, int smp, int od);
        int d, half, w, r0, bad_c, bad_s, bad_d, fc, fa, fe;
        d = (f + 1) << n;
        half = d / 2;
        w = 2 * d + 16;
        set_ctrl(1, 0, smp, n, od, f);
        repeat (300) @(negedge clk_ref);
        capture(w);
        r0 = -1;
        for (int c = 1; c < w; c++) if (r0 < 0 && !cs[c-1] && cs[c]) r0 = c;
        if (r0 < 0) begin
            check(1'b0, $sformatf("R2 R3 no rising edge D=%0d", d), 0, 1);
            return;
        end
        bad_c = 0; bad_s = 0; bad_d = 0; fc = -1; fa = 0; fe = 0;
        for (int c = 0; c < w; c++) begin
            bit ec, es, ed;
            ec = pmod(c - r0, d) < half;
            es = pmod(c - r0 - smp, d) == 0;
            ed = pmod(c - r0 - half - od, d) == 0;
            if (cs[c] != ec) begin
                bad_c++;
                if (fc < 0) begin fc = c; fa = int'(cs[c]); fe = int'(ec); end
            end
            if (ss[c] != es) bad_s++;
            if (ds[c] != ed) bad_d++;
        end
        check(bad_c == 0, $sformatf("R2 R3 card clock N=%0d F=%0d at sample %0d", n, f, fc), fa, fe);
        check(bad_s == 0, $sformatf("R6 sample strobe D=%0d S=%0d mismatching cycles", d, smp), bad_s, 0);
        check(bad_d == 0, $sformatf("R7 drive enable D=%0d P=%0d mismatching cycles", d, od), bad_d, 0);
    endtask

    task automatic measure(output real per, output real hi);
        real t0, t1, t2;
        @(posedge card_clk); t0 = $realtime;
        @(negedge card_clk); t1 = $realtime;
        @(posedge card_clk); t2 = $realtime;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic time_check(string tag, int src, int n, int f, real exp_per, real exp_hi);
        real per, hi;
        set_ctrl(1, src[0], 0, n, 0, f);
        repeat (300) @(negedge clk_ref);
        measure(per, hi);
        check((per > exp_per - TOL) && (per < exp_per + TOL),
              $sformatf("%s period ps N=%0d F=%0d", tag, n, f), int'(per * 1000), int'(exp_per * 1000));
        check((hi > exp_hi - TOL) && (hi < exp_hi + TOL),
              $sformatf("%s high time ps N=%0d F=%0d", tag, n, f), int'(hi * 1000), int'(exp_hi * 1000));
    endtask

    task automatic reload_test();
        bit prev;
        int bad, fk, fa, fe;
        set_ctrl(1, 0, 0, 0, 0, 15);
        repeat (300) @(negedge clk_ref);
        prev = 1'b1;
        forever begin
            @(negedge clk_ref);
            if (!prev && card_clk) break;
            prev = card_clk;
        end
        // mid high phase of a 16-cycle period: ask for divide by 4
        set_ctrl(1, 0, 0, 0, 0, 3);
        capture(32);
        bad = 0; fk = -1; fa = 0; fe = 0;
        for (int k = 1; k <= 32; k++) begin
            bit e;
            if (k < 8)       e = 1'b1;
            else if (k < 16) e = 1'b0;
            else             e = pmod(k - 16, 4) < 2;
            if (cs[k-1] != e) begin
                bad++;
                if (fk < 0) begin fk = k; fa = int'(cs[k-1]); fe = int'(e); end
            end
        end
        check(bad == 0, $sformatf("R8 deferred reload at cycle %0d after rise", fk), fa, fe);
    endtask

    task automatic switch_test();
        set_ctrl(1, 0, 0, 1, 0, 0);
        repeat (300) @(negedge clk_ref);
        hi_min = 1.0e9; lo_min = 1.0e9; have_rise = 1'b0; have_fall = 1'b0;
        mon = 1'b1;
        set_ctrl(1, 1, 0, 1, 0, 0);
        repeat (100) @(negedge clk_ref);
        set_ctrl(1, 0, 0, 1, 0, 0);
        repeat (100) @(negedge clk_ref);
        mon = 1'b0;
        check(hi_min > 10.0 - TOL && hi_min < 1.0e8, "R9 shortest high pulse ps across switch",
              int'(hi_min * 1000), 10000);
        check(lo_min > 10.0 - TOL && lo_min < 1.0e8, "R9 shortest low pulse ps across switch",
              int'(lo_min * 1000), 10000);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk_ref);
        n_cmp++;
        n_bad++;
        $display("FAIL R1..R9 run: actual %0d expected %0d watchdog cycles", WD_CYCLES, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (20) @(negedge clk_ref);
        quiet_check("R1 outputs during reset", 4);
        rst = 1'b0;
        quiet_check("R1 outputs after reset", 20);

        // R1: every field set except the enable
        set_ctrl(0, 0, 5, 2, 3, 7);
        quiet_check("R1 fields ignored while disabled", 60);

        // R2 R3 R6 R7: sweep of every N and F except divide by one
        for (int n = 0; n < 4; n++) begin
            for (int f = 0; f < 16; f++) begin
                if (n == 0 && f == 0) continue;
                run_div(n, f, (n * 16 + f) % 8, (f + 3 * n) % 8);
            end
        end

        reload_test();

        // R4: divide by one on the reference
        time_check("R4 pass-through", 0, 0, 0, real'(REF_PERIOD), real'(REF_PERIOD) / 2.0);

        // R5: PLL source, even and odd division, prescaler only
        time_check("R5 pll D=4", 1, 0, 3, 4.0 * PLL_PERIOD, 2.0 * PLL_PERIOD);
        time_check("R5 pll D=5", 1, 0, 4, 5.0 * PLL_PERIOD, 2.0 * PLL_PERIOD);
        time_check("R5 pll prescale 4", 1, 2, 0, 4.0 * PLL_PERIOD, 2.0 * PLL_PERIOD);

        switch_test();

        // R1: disabling from a long period settles to quiet outputs
        set_ctrl(1, 0, 0, 3, 0, 15);
        repeat (300) @(negedge clk_ref);
        set_ctrl(0, 0, 0, 3, 0, 15);
        repeat (200) @(negedge clk_ref);
        quiet_check("R1 quiet after disable", 40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule